// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This unit sits beside the VLAN lookup of a switch forwarding path. When the lookup finds that a frame's ingress port is not a member of its VLAN, or that the frame's VLAN ID has no table entry, the path sends a one-cycle violation pulse. The pulse carries the source port, the 13-bit VID (twelve VID bits plus a page bit in bit 12) and the two type flags. The unit keeps the first such event and raises an interrupt to the host.

The host services the interrupt with a get-and-clear command. It pulses `cmdStart` and waits for `busy` to fall. At that point the result outputs hold the captured port, flags, VID and an overflow indication, and the pending event is gone. Any violation that arrives while an event is already pending is dropped and only marks overflow.

Top module: `vlan_vio_capture`

## Requirements
- R1: After reset, `irq`, `busy` and every result output (`resPort`, `resMember`, `resMiss`, `resVid`, `resOverflow`) are 0.
- R2: A `cmdStart` pulse while `busy` is 0 makes `busy` 1 for exactly the next cycle. A `cmdStart` while `busy` is 1 is ignored.
- R3: A violation, meaning `vioValid`=1 with at least one of `vioMember` and `vioMiss` set, that arrives while nothing is pending is captured, and `irq` is 1 from the next cycle.
- R4: At the clock edge that ends the `busy` cycle, the results take the captured event. `resPort` gets the source port, `resMember` and `resMiss` get the two flags (both may be 1), and `resVid` gets the VID with bit 12 as the page bit.
- R5: A violation that arrives while an event is pending is dropped and sets a sticky overflow flag. The next get-and-clear reports that flag on `resOverflow` and clears it.
- R6: `irq` is 0 in the cycle after the `busy` cycle. The exception is a violation that arrives during the `busy` cycle: that violation is captured as the new pending event, `irq` stays 1, and no overflow is set.
- R7: A get-and-clear with nothing pending returns `resPort`=0, `resMember`=0, `resMiss`=0, `resVid`=0.
- R8: A `vioValid` pulse with both type flags 0 is ignored. It raises no `irq` and sets no overflow.
- R9: The result outputs change only at the edge that ends a `busy` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vioValid | input | 1 | Violation pulse from the forwarding path |
| vioPort | input | PORT_BITS | Source port of the violation |
| vioVid | input | VID_BITS | Offending VID; bit 12 is the page bit |
| vioMember | input | 1 | Ingress port is not a member of the VLAN |
| vioMiss | input | 1 | VID not present in the table |
| cmdStart | input | 1 | Get-and-clear command request |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Violation pending interrupt |
| resPort | output | PORT_BITS | Captured source port |
| resMember | output | 1 | Captured member-violation flag |
| resMiss | output | 1 | Captured miss-violation flag |
| resVid | output | VID_BITS | Captured VID |
| resOverflow | output | 1 | Violations were dropped while one was pending |

## Verification
A pending bit that is wrongly set or cleared shows on `irq` in the very next cycle. A corrupted capture register stays hidden until the next get-and-clear, and then appears on the result outputs one cycle after `busy` rises. A lost or spurious overflow mark likewise appears only on the next command's `resOverflow`. The bench therefore issues commands often, in random traffic and in directed cases that put a violation inside the `busy` cycle, so that hidden state reaches the ports within a few cycles.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  typedef struct packed {
    logic capture;   // load incoming violation as the pending event
    logic transfer;  // move pending event to results and clear it
    logic setOvf;    // mark a dropped violation
  } vvcStrobe_t;
endpackage

// File: rtl/vvc_ctrl.sv
module vvc_ctrl
  import vvc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       vioHit,
  input  logic       pendingQ,
  output logic       busy,
  output vvcStrobe_t stb
);
  logic busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= cmdStart & ~busyQ;
  end

  always_comb begin
    stb.transfer = busyQ;
    // a violation is taken when the slot is empty or being emptied now
    stb.capture  = vioHit & (~pendingQ | busyQ);
    stb.setOvf   = vioHit & pendingQ & ~busyQ;
  end

  assign busy = busyQ;
endmodule

// File: rtl/vvc_datapath.sv
module vvc_datapath
  import vvc_pkg::*;
#(
  parameter int PORT_BITS = 4,
  parameter int VID_BITS  = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vvcStrobe_t           stb,
  input  logic [PORT_BITS-1:0] vioPort,
  input  logic [VID_BITS-1:0]  vioVid,
  input  logic                 vioMember,
  input  logic                 vioMiss,
  output logic                 pendingQ,
  output logic [PORT_BITS-1:0] resPort,
  output logic                 resMember,
  output logic                 resMiss,
  output logic [VID_BITS-1:0]  resVid,
  output logic                 resOverflow
);
  logic [PORT_BITS-1:0] portQ;
  logic [VID_BITS-1:0]  vidQ;
  logic                 memberQ;
  logic                 missQ;
  logic                 ovfQ;

  // pending event; its data is kept at zero whenever nothing is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      portQ    <= '0;
      vidQ     <= '0;
      memberQ  <= 1'b0;
      missQ    <= 1'b0;
    end else if (stb.capture) begin
      pendingQ <= 1'b1;
      portQ    <= vioPort;
      vidQ     <= vioVid;
      memberQ  <= vioMember;
      missQ    <= vioMiss;
    end else if (stb.transfer) begin
      pendingQ <= 1'b0;
      portQ    <= '0;
      vidQ     <= '0;
      memberQ  <= 1'b0;
      missQ    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ovfQ <= 1'b0;
    else if (stb.transfer) ovfQ <= 1'b0;
    else if (stb.setOvf)   ovfQ <= 1'b1;
  end

  // host-visible result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPort     <= '0;
      resVid      <= '0;
      resMember   <= 1'b0;
      resMiss     <= 1'b0;
      resOverflow <= 1'b0;
    end else if (stb.transfer) begin
      resPort     <= portQ;
      resVid      <= vidQ;
      resMember   <= memberQ;
      resMiss     <= missQ;
      resOverflow <= ovfQ;
    end
  end
endmodule

// File: rtl/vlan_vio_capture.sv
module vlan_vio_capture
  import vvc_pkg::*;
#(
  parameter int PORT_BITS = 4,
  parameter int VID_BITS  = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 vioValid,
  input  logic [PORT_BITS-1:0] vioPort,
  input  logic [VID_BITS-1:0]  vioVid,
  input  logic                 vioMember,
  input  logic                 vioMiss,
  input  logic                 cmdStart,
  output logic                 busy,
  output logic                 irq,
  output logic [PORT_BITS-1:0] resPort,
  output logic                 resMember,
  output logic                 resMiss,
  output logic [VID_BITS-1:0]  resVid,
  output logic                 resOverflow
);
  vvcStrobe_t stb;
  logic       pendingQ;
  logic       vioHit;

  assign vioHit = vioValid & (vioMember | vioMiss);

  vvc_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .vioHit   (vioHit),
    .pendingQ (pendingQ),
    .busy     (busy),
    .stb      (stb)
  );

  vvc_datapath #(.PORT_BITS(PORT_BITS), .VID_BITS(VID_BITS)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .vioPort     (vioPort),
    .vioVid      (vioVid),
    .vioMember   (vioMember),
    .vioMiss     (vioMiss),
    .pendingQ    (pendingQ),
    .resPort     (resPort),
    .resMember   (resMember),
    .resMiss     (resMiss),
    .resVid      (resVid),
    .resOverflow (resOverflow)
  );

  assign irq = pendingQ;
endmodule

// File: rtl/vvc_checker.sv
module vvc_checker #(
  parameter int PORT_BITS = 4,
  parameter int VID_BITS  = 13
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 vioValid,
  input logic                 vioMember,
  input logic                 vioMiss,
  input logic                 cmdStart,
  input logic                 busy,
  input logic                 irq,
  input logic [PORT_BITS-1:0] resPort,
  input logic                 resMember,
  input logic                 resMiss,
  input logic [VID_BITS-1:0]  resVid,
  input logic                 resOverflow
);
  logic hit;
  assign hit = vioValid & (vioMember | vioMiss);

  a_r2_busy_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  a_r2_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdStart) |=> !busy);
  a_r3_irq_rises: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> irq);
  a_r8_no_type_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !hit) |=> !irq);
  a_r6_irq_drops: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hit) |=> !irq);
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !irq) |=> (resPort == '0 && !resMember && !resMiss && resVid == '0));
  a_r4_flag_present: assert property (@(posedge clk) disable iff (!rstN)
    (busy && irq) |=> (resMember || resMiss));
  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable({resPort, resMember, resMiss, resVid, resOverflow}));
endmodule

bind vlan_vio_capture vvc_checker #(.PORT_BITS(PORT_BITS), .VID_BITS(VID_BITS)) i_vvc_checker (
  .clk         (clk),
  .rstN        (rstN),
  .vioValid    (vioValid),
  .vioMember   (vioMember),
  .vioMiss     (vioMiss),
  .cmdStart    (cmdStart),
  .busy        (busy),
  .irq         (irq),
  .resPort     (resPort),
  .resMember   (resMember),
  .resMiss     (resMiss),
  .resVid      (resVid),
  .resOverflow (resOverflow)
);

// File: tb/test_vlan_vio_capture.sv
module test_vlan_vio_capture;
  localparam int PB = 4;
  localparam int VB = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vioValid = 1'b0, vioMember = 1'b0, vioMiss = 1'b0, cmdStart = 1'b0;
  logic [PB-1:0] vioPort = '0;
  logic [VB-1:0] vioVid = '0;
  logic busy, irq, resMember, resMiss, resOverflow;
  logic [PB-1:0] resPort;
  logic [VB-1:0] resVid;

  always #5 clk = ~clk;

  vlan_vio_capture #(.PORT_BITS(PB), .VID_BITS(VB)) i_vlan_vio_capture (
    .clk(clk), .rstN(rstN), .vioValid(vioValid), .vioPort(vioPort),
    .vioVid(vioVid), .vioMember(vioMember), .vioMiss(vioMiss),
    .cmdStart(cmdStart), .busy(busy), .irq(irq), .resPort(resPort),
    .resMember(resMember), .resMiss(resMiss), .resVid(resVid),
    .resOverflow(resOverflow)
  );

  int errors = 0;
  int checks = 0;

  // reference state, built from the requirements
  logic mBusy = 0, mPend = 0, mOvf = 0, mMem = 0, mMiss = 0;
  logic [PB-1:0] mPort = '0;
  logic [VB-1:0] mVid = '0;
  logic rMem = 0, rMiss = 0, rOvf = 0;
  logic [PB-1:0] rPort = '0;
  logic [VB-1:0] rVid = '0;

  function automatic logic isHit(logic v, logic m, logic s);
    return v && (m || s);
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(irq == mPend, tag, "irq", int'(irq), int'(mPend));
    chk(busy == mBusy, tag, "busy", int'(busy), int'(mBusy));
    chk({resPort, resMember, resMiss, resVid, resOverflow} ==
        {rPort, rMem, rMiss, rVid, rOvf}, tag, "results",
        int'({resPort, resMember, resMiss, resVid, resOverflow}),
        int'({rPort, rMem, rMiss, rVid, rOvf}));
  endtask

  // one clock cycle: drive at the falling edge, update the model at the
  // rising edge, compare shortly after it
  task automatic step(input logic cmd, input logic v, input logic mem,
                      input logic miss, input logic [PB-1:0] p,
                      input logic [VB-1:0] vid, input string tag);
    logic h;
    @(negedge clk);
    cmdStart = cmd; vioValid = v; vioMember = mem; vioMiss = miss;
    vioPort = p; vioVid = vid;
    h = isHit(v, mem, miss);
    @(posedge clk);
    if (mBusy) begin
      rPort = mPort; rMem = mMem; rMiss = mMiss; rVid = mVid; rOvf = mOvf;
      mPend = h; mOvf = 0;
      mPort = h ? p : '0; mVid = h ? vid : '0;
      mMem = h ? mem : 1'b0; mMiss = h ? miss : 1'b0;
    end else if (h && !mPend) begin
      mPend = 1; mPort = p; mVid = vid; mMem = mem; mMiss = miss;
    end else if (h) begin
      mOvf = 1;
    end
    mBusy = cmd && !mBusy;
    #1;
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, '0, '0, tag);
  endtask

  task automatic getClear(input string tag);
    step(1, 0, 0, 0, '0, '0, tag);
    idle(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    compareAll("R1");

    // R3 capture, then R4 read back with page bit and member flag
    step(0, 1, 1, 0, 4'd5, 13'h1ABC, "R3");
    idle("R3");
    getClear("R4");
    chk(resPort == 4'd5 && resVid == 13'h1ABC, "R4", "port/vid",
        int'({resPort, resVid}), int'({4'd5, 13'h1ABC}));

    // R4 both flags set
    step(0, 1, 1, 1, 4'd15, 13'h0FFF, "R4");
    getClear("R4");
    chk(resMember && resMiss, "R4", "both flags", int'({resMember, resMiss}), 3);

    // R5 overflow: second violation dropped
    step(0, 1, 0, 1, 4'd2, 13'h0010, "R5");
    step(0, 1, 1, 0, 4'd9, 13'h0999, "R5");
    getClear("R5");
    chk(resOverflow && resPort == 4'd2, "R5", "ovf/port",
        int'({resOverflow, resPort}), int'({1'b1, 4'd2}));
    getClear("R5");
    chk(!resOverflow, "R5", "ovf cleared", int'(resOverflow), 0);

    // R7 empty command
    getClear("R7");
    chk(resPort == 0 && !resMember && !resMiss && resVid == 0, "R7", "zeros",
        int'({resPort, resMember, resMiss, resVid}), 0);

    // R8 typeless pulse
    step(0, 1, 0, 0, 4'd7, 13'h0777, "R8");
    idle("R8");
    chk(!irq, "R8", "irq", int'(irq), 0);
    getClear("R8");
    chk(!resOverflow && resVid == 0, "R8", "no capture",
        int'({resOverflow, resVid}), 0);

    // R6 violation in the busy cycle becomes the new pending event
    step(0, 1, 1, 0, 4'd1, 13'h0111, "R6");
    step(1, 0, 0, 0, '0, '0, "R6");
    step(0, 1, 0, 1, 4'd3, 13'h0333, "R6");
    chk(irq, "R6", "irq kept", int'(irq), 1);
    getClear("R6");
    chk(resPort == 4'd3 && resMiss && !resOverflow, "R6", "new event",
        int'({resPort, resMiss, resOverflow}), int'({4'd3, 1'b1, 1'b0}));

    // R2 command while busy ignored
    step(1, 0, 0, 0, '0, '0, "R2");
    step(1, 0, 0, 0, '0, '0, "R2");
    chk(!busy, "R2", "busy", int'(busy), 0);
    idle("R2");

    // R9 random traffic and commands against the model
    for (int i = 0; i < 3000; i++) begin
      logic c, v, m, s;
      c = ($urandom % 6) == 0;
      v = ($urandom % 3) == 0;
      m = $urandom % 2;
      s = $urandom % 2;
      step(c, v, m, s, PB'($urandom), VB'($urandom), "R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule